// File: doc/BRIEF.md
# Universal Two-Pattern Test Sequencer

This block is a built-in self-test pattern source for an n-input combinational network built from NAND and XOR stages, with three control lines and one extra observable output added for testing. It emits a fixed universal sequence of 2n+10 vectors. In that sequence, each test vector comes right after the vector that initialises it, so that an open transistor in the network under test shows up as a held, stale output value.

The sequence is not stored in a ROM. It is formed from a small phase register and a shared index counter. The sequence has three parts:
- a five-vector head that exercises the control lines;
- a walking-zero section of 2n vectors, in which every single-zero vector is followed by an all-ones vector;
- a five-vector tail with all data inputs low.

A start pulse loads the first vector. Each advance pulse steps to the next vector. After the last vector, the block raises a done flag.

Top module: `tps_seq`

## Requirements
- R1: While reset is held and after it is released, `vec_o` is all zeros and `valid_o` and `done_o` are 0.
- R2: The vector is packed as {c1, c2, c3, x1..xn}, with c1 at bit n+2, c3 at bit n and xj at bit n-j. One cycle after a start pulse, `valid_o` is 1 and the vector is c=011 with every x bit set to 1.
- R3: The first five vectors have the c fields 011, 001, 011, 010, 011 in that order, and all x bits are 1.
- R4: Vectors 6 to 2n+5 come in pairs, for j = 1..n in rising order. The first vector of each pair is c=011 with only xj at 0. The second vector of each pair is c=011 with all x bits at 1.
- R5: The last five vectors have all x bits at 0, and their c fields are 000, 100, 000, 010, 000 in that order.
- R6: The sequence is 2n+10 vectors long. One cycle after an advance on the last vector, `valid_o` is 0, `done_o` is 1 and `vec_o` is zero. This state holds until the next start.
- R7: An advance while idle or done changes no output.
- R8: A start while the sequence is running, or while it is done, restarts at the first vector one cycle later and clears `done_o`. A start takes priority over an advance in the same cycle.
- R9: Without start or advance, the current vector and `valid_o` are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin or restart the sequence |
| adv_i | input | 1 | Step to the next vector |
| vec_o | output | N+3 | Current vector {c1,c2,c3,x1..xn} |
| valid_o | output | 1 | Vector on `vec_o` belongs to the sequence |
| done_o | output | 1 | Sequence finished |

## Verification
Every output depends on a single state register, so the response to a start or advance pulse is due exactly one clock edge after the edge that samples the pulse. The bench drives each pulse on a falling edge and clears it after one cycle. It compares the outputs on the next falling edge, one full register stage later and clear of the active edge. Hold and ignore cases are checked in the same way: the bench looks at the outputs one cycle after a quiet or ignored cycle and expects the previous value.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HEAD = 3'd1,
        PH_WALK = 3'd2,
        PH_TAIL = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    localparam int unsigned EDGE_LEN = 5;

    // control triple {c1,c2,c3} for head slot k
    function automatic logic [2:0] head_ctl(input logic [2:0] k);
        logic [2:0] r;
        case (k)
            3'd1:    r = 3'b001;
            3'd3:    r = 3'b010;
            default: r = 3'b011;
        endcase
        return r;
    endfunction

    // control triple {c1,c2,c3} for tail slot k
    function automatic logic [2:0] tail_ctl(input logic [2:0] k);
        logic [2:0] r;
        case (k)
            3'd1:    r = 3'b100;
            3'd3:    r = 3'b010;
            default: r = 3'b000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tps_ctrl.sv
module tps_ctrl
    import tps_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          adv_i,
    output phase_e        phase_o,
    output logic [IW-1:0] idx_o
);

    localparam logic [IW-1:0] EDGE_LAST = IW'(EDGE_LEN - 1);
    localparam logic [IW-1:0] WALK_LAST = IW'(2 * N - 1);

    typedef struct packed {
        phase_e        phase;
        logic [IW-1:0] idx;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     running;

    assign running = (st_q.phase == PH_HEAD) || (st_q.phase == PH_WALK) ||
                     (st_q.phase == PH_TAIL);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.phase = PH_HEAD;
            st_d.idx   = '0;
        end else if (adv_i && running) begin
            case (st_q.phase)
                PH_HEAD: begin
                    if (st_q.idx == EDGE_LAST) begin
                        st_d.phase = PH_WALK;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                PH_WALK: begin
                    if (st_q.idx == WALK_LAST) begin
                        st_d.phase = PH_TAIL;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (st_q.idx == EDGE_LAST) begin
                        st_d.phase = PH_DONE;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign idx_o   = st_q.idx;

    // R7
    idle_adv_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !start_i) |=> ($stable(st_q.phase) && $stable(st_q.idx)));

    // R8
    restart_head_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (st_q.phase == PH_HEAD && st_q.idx == '0));

    // R9
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !adv_i) |=> ($stable(st_q.phase) && $stable(st_q.idx)));

    // R6
    done_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_TAIL && st_q.idx == EDGE_LAST && adv_i && !start_i)
        |=> (st_q.phase == PH_DONE));

    // R4
    walk_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_WALK && st_q.idx != WALK_LAST && adv_i && !start_i)
        |=> (st_q.phase == PH_WALK && st_q.idx == $past(st_q.idx) + 1'b1));

endmodule

// File: rtl/tps_vec_form.sv
module tps_vec_form
    import tps_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase_i,
    input  logic [IW-1:0] idx_i,
    output logic [2:0]    ctl_o,
    output logic [N-1:0]  dat_o
);

    logic           in_walk;
    logic           zero_slot;
    logic [IW-1:0]  zero_pos;
    logic [N-1:0]   base_dat;
    logic [N-1:0]   clear_mask;

    assign in_walk   = (phase_i == PH_WALK);
    assign zero_slot = in_walk && !idx_i[0];
    assign zero_pos  = idx_i >> 1;

    always_comb begin
        case (phase_i)
            PH_HEAD: ctl_o = head_ctl(idx_i[2:0]);
            PH_WALK: ctl_o = 3'b011;
            PH_TAIL: ctl_o = tail_ctl(idx_i[2:0]);
            default: ctl_o = 3'b000;
        endcase
    end

    assign base_dat = (phase_i == PH_HEAD || in_walk) ? '1 : '0;

    // x(g+1) sits at dat bit N-1-g
    for (genvar g = 0; g < N; g++) begin : g_mask
        assign clear_mask[N-1-g] = zero_slot && (zero_pos == IW'(g));
    end

    assign dat_o = base_dat & ~clear_mask;

    // R4
    walk_zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        in_walk |-> ($countones(dat_o) == (idx_i[0] ? N : N - 1)));

    // R5
    tail_data_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_TAIL) |-> (dat_o == '0));

endmodule

// File: rtl/tps_seq.sv
module tps_seq
    import tps_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         adv_i,
    output logic [N+2:0] vec_o,
    output logic         valid_o,
    output logic         done_o
);

    localparam int unsigned WALK_BITS = (2 * N > 1) ? $clog2(2 * N) : 1;
    localparam int unsigned IW        = (WALK_BITS > 3) ? WALK_BITS : 3;

    phase_e        phase;
    logic [IW-1:0] idx;
    logic [2:0]    ctl;
    logic [N-1:0]  dat;

    tps_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .adv_i   (adv_i),
        .phase_o (phase),
        .idx_o   (idx)
    );

    tps_vec_form #(.N(N), .IW(IW)) u_form (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase),
        .idx_i   (idx),
        .ctl_o   (ctl),
        .dat_o   (dat)
    );

    assign valid_o = (phase == PH_HEAD) || (phase == PH_WALK) || (phase == PH_TAIL);
    assign done_o  = (phase == PH_DONE);
    assign vec_o   = valid_o ? {ctl, dat} : '0;

    // R1
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (vec_o == '0));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

endmodule

// File: tb/tps_seq_bench.sv
module tps_seq_bench;

    localparam int N   = 4;
    localparam int VW  = N + 3;
    localparam int LEN = 2 * N + 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          adv_i = 1'b0;
    logic [VW-1:0] vec_o;
    logic          valid_o;
    logic          done_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tps_seq #(.N(N)) u_tps_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .adv_i(adv_i),
        .vec_o(vec_o), .valid_o(valid_o), .done_o(done_o)
    );

    function automatic logic [VW-1:0] exp_vec(input int k);
        logic [2:0]   c;
        logic [N-1:0] x;
        int m;
        if (k < 5) begin
            c = (k == 1) ? 3'b001 : (k == 3) ? 3'b010 : 3'b011;
            x = '1;
        end else if (k < 5 + 2 * N) begin
            m = k - 5;
            c = 3'b011;
            x = '1;
            if (m % 2 == 0) x[N - 1 - m / 2] = 1'b0;
        end else begin
            m = k - 5 - 2 * N;
            c = (m == 1) ? 3'b100 : (m == 3) ? 3'b010 : 3'b000;
            x = '0;
        end
        return {c, x};
    endfunction

    task automatic check(input string req, input logic [VW-1:0] ev,
                         input logic ep_valid, input logic ep_done);
        total++;
        if (vec_o !== ev || valid_o !== ep_valid || done_o !== ep_done) begin
            bad++;
            $display("FAIL %s: vec=%b valid=%b done=%b expected vec=%b valid=%b done=%b",
                     req, vec_o, valid_o, done_o, ev, ep_valid, ep_done);
        end
    endtask

    // called on a falling edge; one cycle of stimulus, returns on next falling edge
    task automatic cyc(input logic s, input logic a);
        start_i = s;
        adv_i   = a;
        @(negedge clk);
        start_i = 1'b0;
        adv_i   = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        check("R1 in reset", '0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", '0, 1'b0, 1'b0);
    endtask

    task automatic t_idle_adv();
        cyc(1'b0, 1'b1);
        check("R7 advance while idle", '0, 1'b0, 1'b0);
    endtask

    task automatic t_full_run();
        cyc(1'b1, 1'b0);
        check("R2 first vector", exp_vec(0), 1'b1, 1'b0);
        for (int k = 0; k < LEN; k++) begin
            if (k < 5)               check("R3 head vector", exp_vec(k), 1'b1, 1'b0);
            else if (k < 5 + 2 * N)  check("R4 walking pair", exp_vec(k), 1'b1, 1'b0);
            else                     check("R5 tail vector", exp_vec(k), 1'b1, 1'b0);
            if (k == 6) begin
                cyc(1'b0, 1'b0);
                check("R9 hold without advance", exp_vec(k), 1'b1, 1'b0);
            end
            cyc(1'b0, 1'b1);
        end
        check("R6 done after last vector", '0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        check("R6 done held", '0, 1'b0, 1'b1);
    endtask

    task automatic t_done_adv();
        cyc(1'b0, 1'b1);
        check("R7 advance while done", '0, 1'b0, 1'b1);
    endtask

    task automatic t_restart();
        cyc(1'b1, 1'b0);
        check("R8 start from done", exp_vec(0), 1'b1, 1'b0);
        for (int k = 0; k < 7; k++) cyc(1'b0, 1'b1);
        check("R4 mid-run vector", exp_vec(7), 1'b1, 1'b0);
        cyc(1'b1, 1'b1);
        check("R8 start beats advance", exp_vec(0), 1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        check("R3 second vector after restart", exp_vec(1), 1'b1, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_adv();
        t_full_run();
        t_done_adv();
        t_restart();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule